// File: doc/BRIEF.md
# Transmit Frame Abort with Corrupted Check Sequence

This block sits in a transmit byte path just before the line interface. It forwards frame bytes one cycle after accepting them and keeps a running CRC-32 over everything it has forwarded. When a frame ends normally, it appends the four-byte frame check sequence itself. It also counts how many bits of the current frame have already gone out.

An abort request can arrive in the middle of a frame, for example after a bus error while the frame was being fetched. The block then ends the frame so that no receiver can accept it. If fewer than 512 bits have been forwarded, the block signals an immediate cut-off and the line produces a runt. If 512 or more bits have left, the block closes the frame with the bitwise complement of the correct check sequence, starting at the next byte slot. In both cases, the input bytes that the frame still has are consumed and thrown away, up to and including the one marked last.

The output has no backpressure: the line takes one byte per cycle whenever `tx_valid` is high. `in_ready` is low only while the block emits check-sequence bytes.

Top module: `txab_fcs_abort`

## Requirements
- R1: After reset, `tx_valid`, `tx_last` and `tx_cut` are 0 and `in_ready` is 1.
- R2: A byte accepted while a frame is passing (`in_valid` and `in_ready` high, no abort taking effect) appears on `tx_data` with `tx_valid` high in the next cycle, and bytes keep their input order.
- R3: After the byte marked `in_last` is accepted, the block emits four check bytes in the following four cycles. These bytes are the CRC-32 (reflected polynomial 0xEDB88320, initial value all ones, final complement) over the frame's bytes, least significant byte first. `tx_last` is high only with the fourth byte, and `in_ready` is low during those four cycles.
- R4: An abort that takes effect when fewer than 64 bytes (512 bits) of the frame have been forwarded produces a single-cycle `tx_cut` pulse in the next cycle. No further `tx_valid` and no `tx_last` follow for that frame.
- R5: An abort that takes effect when 64 or more bytes have been forwarded is followed by one cycle with `tx_valid` low. Four check bytes then follow that are the bitwise complement of the R3 value over the forwarded bytes, with `tx_last` on the fourth.
- R6: The input byte present in the cycle an abort takes effect is discarded. So are all later input bytes of the frame, up to and including the one marked `in_last`. None of them reaches the output, and `in_ready` stays high while they are drained.
- R7: An abort takes effect only after the frame's first byte has been accepted and before its last byte has been accepted. An abort raised with the first byte, during the check-sequence trailer or between frames has no effect on the output.
- R8: The bit count starts from zero for every frame: a short frame aborted after a long frame still gets a cut-off.
- R9: An abort with exactly 63 bytes forwarded gives a cut-off, and an abort with exactly 64 bytes forwarded gives a complemented trailer.
- R10: `tx_cut` is never high in the same cycle as `tx_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DATA_W | Frame byte offered |
| in_valid | input | 1 | `in_data` is valid |
| in_last | input | 1 | Offered byte is the last of its frame |
| in_ready | output | 1 | Block accepts the offered byte this cycle |
| abort_req | input | 1 | Request to abort the current frame |
| tx_data | output | DATA_W | Byte towards the line |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_last | output | 1 | Byte on `tx_data` ends the frame |
| tx_cut | output | 1 | Pulse: end the frame at once as a runt |

## Verification
On every cycle, the embedded assertions check three things: the one-cycle forwarding of accepted bytes, the separation of the cut pulse from data and from itself, and the silence of the output while a frame is being drained. The cycle-by-cycle checks cannot judge whether a frame was closed correctly. The bench's frame scenarios show this. They compare the trailer value against an independently computed CRC, check the choice between runt and complemented trailer at 63 and 64 bytes and after a long frame, and confirm that aborts outside a frame leave the output unchanged.

// File: rtl/txab_pkg.sv
package txab_pkg;

   typedef enum logic [1:0] {
      ST_PASS  = 2'd0,
      ST_TRAIL = 2'd1,
      ST_DRAIN = 2'd2
   } txab_state_e;

   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

   // one byte folded into a reflected CRC-32 register, bit by bit
   function automatic logic [31:0] crc_fold(input logic [31:0] crc, input logic [7:0] b);
      logic [31:0] r;
      r = crc ^ {24'd0, b};
      for (int k = 0; k < 8; k++) begin
         r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/txab_crc.sv
module txab_crc
   import txab_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int FCS_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fold,
   input  logic              restart,
   input  logic [DATA_W-1:0] din,
   output logic [FCS_W-1:0]  crc_q
);
   localparam logic [FCS_W-1:0] SEED = '1;

   generate
      if (FCS_W != 32) begin : g_bad_fcs
         $error("txab_crc: only a 32-bit check sequence is supported");
      end
      if (DATA_W != 8) begin : g_bad_dw
         $error("txab_crc: byte-wide data path required");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       crc_q <= SEED;
      else if (fold)    crc_q <= crc_fold(crc_q, din);
      else if (restart) crc_q <= SEED;
   end
endmodule

// File: rtl/txab_bitcnt.sv
module txab_bitcnt #(
   parameter int DATA_W      = 8,
   parameter int THRESH_BITS = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic restart,
   output logic reached
);
   localparam int THRESH_UNITS = THRESH_BITS / DATA_W;
   localparam int CNT_W        = $clog2(THRESH_UNITS + 1);

   generate
      if (THRESH_BITS % DATA_W != 0 || THRESH_UNITS < 1) begin : g_bad_thr
         $error("txab_bitcnt: threshold must be a positive multiple of the data width");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   assign reached = (cnt_q == CNT_W'(THRESH_UNITS));

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt_q <= '0;
      else if (inc && !reached)  cnt_q <= cnt_q + 1'b1;
      else if (restart)          cnt_q <= '0;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(THRESH_UNITS)); // R8
endmodule

// File: rtl/txab_trailer.sv
module txab_trailer #(
   parameter int DATA_W = 8,
   parameter int FCS_W  = 32,
   parameter int IDX_W  = 2
) (
   input  logic [FCS_W-1:0]  crc_q,
   input  logic [IDX_W-1:0]  idx,
   input  logic              corrupt,
   output logic [DATA_W-1:0] lane
);
   localparam int LANES = FCS_W / DATA_W;

   // normal trailer is the complemented register; the abort trailer drops the complement
   logic [FCS_W-1:0]  word;
   logic [DATA_W-1:0] lanes [LANES];

   assign word = corrupt ? crc_q : ~crc_q;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lanes[g] = word[g*DATA_W +: DATA_W];
      end
   endgenerate

   assign lane = lanes[idx];
endmodule

// File: rtl/txab_fcs_abort.sv
module txab_fcs_abort
   import txab_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int FCS_W       = 32,
   parameter int THRESH_BITS = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   input  logic              in_last,
   output logic              in_ready,
   input  logic              abort_req,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_valid,
   output logic              tx_last,
   output logic              tx_cut
);
   localparam int LANES = FCS_W / DATA_W;
   localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam logic [IDX_W-1:0] IDX_END = IDX_W'(LANES - 1);

   generate
      if (FCS_W % DATA_W != 0) begin : g_bad_lanes
         $error("txab_fcs_abort: check sequence must be whole bytes");
      end
   endgenerate

   txab_state_e       state_q;
   logic              started_q;
   logic              corrupt_q;
   logic              drain_q;
   logic [IDX_W-1:0]  idx_q;
   logic [FCS_W-1:0]  crc_q;
   logic [DATA_W-1:0] lane;
   logic              reached;
   logic              abort_hit;
   logic              pass_accept;
   logic              trail_done;
   logic              runt_cut;
   logic              restart;

   assign in_ready    = (state_q != ST_TRAIL);
   assign abort_hit   = (state_q == ST_PASS) && started_q && abort_req;
   assign pass_accept = (state_q == ST_PASS) && in_valid && !abort_hit;
   assign trail_done  = (state_q == ST_TRAIL) && (idx_q == IDX_END);
   assign runt_cut    = abort_hit && !reached;
   assign restart     = trail_done || runt_cut;

   txab_crc #(.DATA_W(DATA_W), .FCS_W(FCS_W)) u_crc (
      .clk(clk), .rst_n(rst_n), .fold(pass_accept), .restart(restart),
      .din(in_data), .crc_q(crc_q));

   txab_bitcnt #(.DATA_W(DATA_W), .THRESH_BITS(THRESH_BITS)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(pass_accept), .restart(restart),
      .reached(reached));

   txab_trailer #(.DATA_W(DATA_W), .FCS_W(FCS_W), .IDX_W(IDX_W)) u_trl (
      .crc_q(crc_q), .idx(idx_q), .corrupt(corrupt_q), .lane(lane));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_PASS;
         started_q <= 1'b0;
         corrupt_q <= 1'b0;
         drain_q   <= 1'b0;
         idx_q     <= '0;
         tx_data   <= '0;
         tx_valid  <= 1'b0;
         tx_last   <= 1'b0;
         tx_cut    <= 1'b0;
      end else begin
         tx_valid <= 1'b0;
         tx_last  <= 1'b0;
         tx_cut   <= 1'b0;
         unique case (state_q)
            ST_PASS: begin
               if (abort_hit) begin
                  started_q <= 1'b0;
                  drain_q   <= !(in_valid && in_last);
                  if (reached) begin
                     state_q   <= ST_TRAIL;
                     corrupt_q <= 1'b1;
                     idx_q     <= '0;
                  end else begin
                     tx_cut  <= 1'b1;
                     state_q <= (in_valid && in_last) ? ST_PASS : ST_DRAIN;
                  end
               end else if (in_valid) begin
                  tx_valid <= 1'b1;
                  tx_data  <= in_data;
                  if (in_last) begin
                     state_q   <= ST_TRAIL;
                     corrupt_q <= 1'b0;
                     drain_q   <= 1'b0;
                     idx_q     <= '0;
                     started_q <= 1'b0;
                  end else begin
                     started_q <= 1'b1;
                  end
               end
            end
            ST_TRAIL: begin
               tx_valid <= 1'b1;
               tx_data  <= lane;
               if (idx_q == IDX_END) begin
                  tx_last <= 1'b1;
                  state_q <= drain_q ? ST_DRAIN : ST_PASS;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_DRAIN: begin
               if (in_valid && in_last) state_q <= ST_PASS;
            end
            default: state_q <= ST_PASS;
         endcase
      end
   end

   AST_PASS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      pass_accept |=> (tx_valid && tx_data == $past(in_data))); // R2
   AST_LAST_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid); // R3
   AST_CUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cut |=> !tx_cut); // R4
   AST_DRAIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DRAIN && $past(state_q == ST_DRAIN)) |-> !tx_valid); // R6
   AST_CUT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cut |-> !tx_valid); // R10
endmodule

// File: tb/txab_fcs_abort_test.sv
`timescale 1ns/1ps
module txab_fcs_abort_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_valid = 1'b0;
   logic       in_last = 1'b0;
   logic       in_ready;
   logic       abort_req = 1'b0;
   logic [7:0] tx_data;
   logic       tx_valid, tx_last, tx_cut;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   txab_fcs_abort uut (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_last(in_last), .in_ready(in_ready), .abort_req(abort_req),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_cut(tx_cut));

   // output monitor
   logic [7:0] cap [0:4095];
   int capn = 0, cutn = 0, lastn = 0, overlap = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_valid) begin
            cap[capn] = tx_data;
            capn = capn + 1;
         end
         if (tx_cut) cutn = cutn + 1;
         if (tx_last) lastn = lastn + 1;
         if (tx_cut && tx_valid) overlap = overlap + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] fbyte(input int seed, input int i);
      return 8'((seed * 31 + i * 7 + (i >> 3)) & 255);
   endfunction

   function automatic logic [31:0] ref_crc(input int seed, input int n);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < n; i++) begin
         c ^= {24'd0, fbyte(seed, i)};
         for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      return ~c;
   endfunction

   task automatic send_frame(input int len, input int ab, input int seed);
      for (int i = 0; i < len; i++) begin
         bit acc = 1'b0;
         in_valid  = 1'b1;
         in_data   = fbyte(seed, i);
         in_last   = (i == len - 1);
         abort_req = (i == ab);
         while (!acc) begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #1;
         end
         abort_req = 1'b0;
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   // kind: 0 normal, 1 runt, 2 complemented trailer
   task automatic run_frame(input int len, input int ab, input int seed, input string req);
      int b0 = capn, c0 = cutn, l0 = lastn;
      int kind, nd, ntot, bad;
      logic [31:0] fcs;
      if (ab <= 0 || ab >= len) kind = 0;
      else if (ab < 64) kind = 1;
      else kind = 2;
      nd   = (kind == 0) ? len : ab;
      ntot = (kind == 1) ? nd : nd + 4;
      fcs  = ref_crc(seed, nd);
      if (kind == 2) fcs = ~fcs;
      send_frame(len, ab, seed);
      repeat (8) @(posedge clk);
      #1;
      chk(capn - b0 == ntot, req, "byte count", 32'(capn - b0), 32'(ntot));
      bad = 0;
      for (int i = 0; i < nd && i < capn - b0; i++)
         if (cap[b0 + i] != fbyte(seed, i)) bad++;
      chk(bad == 0, req, "data bytes (R2)", 32'(bad), 32'd0);
      if (kind != 1 && capn - b0 == ntot)
         chk({cap[b0+nd+3], cap[b0+nd+2], cap[b0+nd+1], cap[b0+nd]} == fcs, req,
             "trailer", {cap[b0+nd+3], cap[b0+nd+2], cap[b0+nd+1], cap[b0+nd]}, fcs);
      chk(cutn - c0 == (kind == 1 ? 1 : 0), req, "cut pulses", 32'(cutn - c0),
          32'(kind == 1 ? 1 : 0));
      chk(lastn - l0 == (kind == 1 ? 0 : 1), req, "last markers", 32'(lastn - l0),
          32'(kind == 1 ? 0 : 1));
   endtask

   localparam int NV = 10;
   localparam int VLEN [NV] = '{10, 70, 20, 80, 80, 100, 1, 30, 64, 66};
   localparam int VAB  [NV] = '{999, 999, 5, 63, 64, 90, 999, 0, 63, 1};

   initial begin : watchdog
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      @(negedge clk);
      chk(!tx_valid && !tx_last && !tx_cut && in_ready, "R1", "reset outputs",
          {28'd0, tx_valid, tx_last, tx_cut, in_ready}, 32'h1);
      @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk);
      #1;

      for (int v = 0; v < NV; v++) begin
         // v1 R3 long normal, v2 R4 and R8 runt after long frame, v3/v4 R9,
         // v5 R5, v7 R7 abort with first byte, v8 R6 abort with last byte, v9 R6 drain
         run_frame(VLEN[v], VAB[v], v + 3, $sformatf("R3/R4/R5 vec%0d", v));
      end

      // R7: abort held between frames and throughout a trailer has no effect
      begin
         int b0, l0, lowcyc;
         logic [31:0] fcs;
         abort_req = 1'b1;
         repeat (5) @(posedge clk);
         #1;
         abort_req = 1'b0;
         b0 = capn; l0 = lastn;
         send_frame(12, 999, 40);
         abort_req = 1'b1;
         lowcyc = 0;
         repeat (6) begin
            @(negedge clk);
            if (!in_ready) lowcyc++;
         end
         abort_req = 1'b0;
         repeat (4) @(posedge clk);
         #1;
         fcs = ref_crc(40, 12);
         chk(capn - b0 == 16, "R7", "byte count with idle/trailer abort", 32'(capn - b0), 32'd16);
         if (capn - b0 == 16)
            chk({cap[b0+15], cap[b0+14], cap[b0+13], cap[b0+12]} == fcs, "R7",
                "trailer kept normal", {cap[b0+15], cap[b0+14], cap[b0+13], cap[b0+12]}, fcs);
         chk(lastn - l0 == 1, "R7", "one last marker", 32'(lastn - l0), 32'd1);
         chk(lowcyc == 4, "R3", "in_ready low cycles in trailer", 32'(lowcyc), 32'd4);
      end

      // R8: long frame, then short runt (counter restart)
      run_frame(90, 999, 50, "R8 long");
      run_frame(40, 39, 51, "R8 runt after long");

      chk(overlap == 0, "R10", "cut overlapping data", 32'(overlap), 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule